// File: doc/BRIEF.md
# I2C Transfer Byte Counter

This block tracks how many data bytes remain in an I2C transfer and decides what happens when that count runs out. It sits beside a byte-level I2C engine. The engine sends it a one-cycle pulse for each acknowledged byte. Software loads an 8-bit count and picks one of three end-of-count actions with two control inputs:

- **Reload:** raise a reload-request flag and hold SCL low until software supplies a new non-zero count.
- **Automatic end:** issue a one-cycle STOP request to the engine.
- **Software end:** raise a transfer-complete flag, hold SCL low, and wait until software sets its stop bit.

The byte pulse is an event stream with no back-pressure. Each pulse is taken in the cycle it appears, and the engine never has to wait for this block. Instead, the block applies back-pressure to the bus itself through its SCL-stretch request, while a flag is pending. All other pins are plain level controls or status. Transfers longer than 255 bytes, and slave operation where software controls the byte count, must run in reload mode.

Top module: `i2c_xfer_cnt`

## Requirements
- R1: While the synchronous reset `rst` is high at a clock edge, the following are all 0 after that edge: `count`, `reload_flag`, `done_flag`, `stop_req` and `scl_hold`.
- R2: A `cnt_wr` pulse loads `cnt_wdata` into `count` at that edge. It takes priority over a `byte_ack` pulse in the same cycle, and that byte pulse is then not counted.
- R3: A `byte_ack` pulse with no write lowers a non-zero `count` by one at that edge. When `count` is already 0, the pulse is ignored and `count` stays 0.
- R4: In reload mode (`reload_en`=1), the edge at which `count` goes from 1 to 0 sets `reload_flag`. `irq_reload` equals `reload_flag` AND `reload_ie`.
- R5: `scl_hold` is 1 exactly when `reload_flag` or `done_flag` is 1.
- R6: A write of a non-zero count clears `reload_flag` at that edge. A write of zero leaves it set.
- R7: With `autoend_en`=1 and `reload_en`=0, the edge at which `count` reaches 0 raises `stop_req` for exactly one cycle. Neither flag is set.
- R8: With both `reload_en` and `autoend_en` at 1, reaching 0 behaves as reload mode: `reload_flag` is set and no automatic `stop_req` is issued.
- R9: With both modes at 0, reaching 0 sets `done_flag`. `irq_done` equals `done_flag` AND `done_ie`.
- R10: A `stop_set` pulse while `done_flag` is 1 raises `stop_req` for one cycle and clears `done_flag`. If the count reaches 0 in software-end mode in that same cycle, the flag is set again. A `stop_set` pulse while `done_flag` is 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cnt_wr | input | 1 | One-cycle count write strobe |
| cnt_wdata | input | 8 | Count value to load |
| byte_ack | input | 1 | One-cycle pulse per acknowledged byte |
| reload_en | input | 1 | Reload mode enable |
| autoend_en | input | 1 | Automatic-end mode enable |
| stop_set | input | 1 | Software stop command pulse |
| reload_ie | input | 1 | Reload-request interrupt enable |
| done_ie | input | 1 | Transfer-complete interrupt enable |
| count | output | 8 | Bytes remaining |
| reload_flag | output | 1 | Reload request pending |
| done_flag | output | 1 | Transfer complete, waiting for software |
| stop_req | output | 1 | One-cycle STOP-generation request to the engine |
| scl_hold | output | 1 | Request to stretch SCL |
| irq_reload | output | 1 | Reload-request interrupt |
| irq_done | output | 1 | Transfer-complete interrupt |

## Verification
The bench targets several collisions:

- **Write against byte pulse:** a write and a byte pulse in the same cycle. A design that gives the byte priority loads a count one too small.
- **Byte at zero:** a byte pulse at count 0. A design without a floor wraps to 255 and later fires a spurious end event.
- **Zero write:** a zero written during a reload request. A design that clears the flag on any write releases SCL with nothing to count.
- **Both modes on:** reload and automatic end enabled together. A design with the wrong priority emits a STOP in the middle of a transfer.
- **Stop command timing:** a software stop both with and without the complete flag set. A design that ignores the flag emits stray STOPs, and one that forgets to clear the flag keeps SCL stretched.

Random mode changes and short counts make these collisions happen many times. Each one is compared cycle by cycle against a bench model.

// File: rtl/i2c_xfer_cnt_pkg.sv
package i2c_xfer_cnt_pkg;

  typedef enum logic [1:0] {
    END_SOFT   = 2'd0,
    END_AUTO   = 2'd1,
    END_RELOAD = 2'd2
  } end_mode_e;

  // reload dominates automatic end
  function automatic end_mode_e pick_end(input logic reload, input logic autoend);
    if (reload)       return END_RELOAD;
    else if (autoend) return END_AUTO;
    else              return END_SOFT;
  endfunction

  localparam int unsigned NUM_IRQ = 2;
  localparam int unsigned IRQ_RELOAD = 0;
  localparam int unsigned IRQ_DONE   = 1;

endpackage

// File: rtl/xfer_cnt_reg.sv
module xfer_cnt_reg #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  input  logic             byte_ack,
  output logic [CNT_W-1:0] count,
  output logic             hit,
  output logic             wr_nonzero
);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] ZERO = '0;

  logic take_byte;

  assign take_byte  = byte_ack && !wr && (count != ZERO);
  assign hit        = take_byte && (count == ONE);
  assign wr_nonzero = wr && (wdata != ZERO);

  always_ff @(posedge clk) begin
    if (rst)            count <= ZERO;
    else if (wr)        count <= wdata;
    else if (take_byte) count <= count - ONE;
  end

  p_load_r2: assert property (@(posedge clk) disable iff (rst)
    wr |=> count == $past(wdata));

  p_dec_r3: assert property (@(posedge clk) disable iff (rst)
    (byte_ack && !wr && count != ZERO) |=> count == $past(count) - ONE);

  p_floor_r3: assert property (@(posedge clk) disable iff (rst)
    (byte_ack && !wr && count == ZERO) |=> count == ZERO);

endmodule

// File: rtl/xfer_end_ctrl.sv
module xfer_end_ctrl
  import i2c_xfer_cnt_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic hit,
  input  logic wr_nonzero,
  input  logic reload_en,
  input  logic autoend_en,
  input  logic stop_set,
  output logic reload_flag,
  output logic done_flag,
  output logic stop_req
);
  end_mode_e mode;
  logic      hit_reload, hit_auto, hit_soft, sw_stop;

  assign mode       = pick_end(reload_en, autoend_en);
  assign hit_reload = hit && (mode == END_RELOAD);
  assign hit_auto   = hit && (mode == END_AUTO);
  assign hit_soft   = hit && (mode == END_SOFT);
  assign sw_stop    = stop_set && done_flag;

  always_ff @(posedge clk) begin
    if (rst)             reload_flag <= 1'b0;
    else if (hit_reload) reload_flag <= 1'b1;
    else if (wr_nonzero) reload_flag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)           done_flag <= 1'b0;
    else if (hit_soft) done_flag <= 1'b1;
    else if (sw_stop)  done_flag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) stop_req <= 1'b0;
    else     stop_req <= hit_auto || sw_stop;
  end

  p_reload_set_r4: assert property (@(posedge clk) disable iff (rst)
    (hit && reload_en) |=> reload_flag);

  p_zero_write_keeps_r6: assert property (@(posedge clk) disable iff (rst)
    (reload_flag && !wr_nonzero) |=> reload_flag);

  p_stop_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    stop_req |=> !stop_req);

  p_reload_wins_r8: assert property (@(posedge clk) disable iff (rst)
    (hit && reload_en && autoend_en && !(stop_set && done_flag)) |=> !stop_req);

  p_sw_stop_r10: assert property (@(posedge clk) disable iff (rst)
    (stop_set && done_flag) |=> stop_req);

  p_no_stray_stop_r10: assert property (@(posedge clk) disable iff (rst)
    (!hit && !(stop_set && done_flag)) |=> !stop_req);

endmodule

// File: rtl/xfer_irq_gen.sv
module xfer_irq_gen #(
  parameter int unsigned NSRC = 2
) (
  input  logic [NSRC-1:0] flags,
  input  logic [NSRC-1:0] enables,
  output logic [NSRC-1:0] irq,
  output logic            hold
);
  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign irq[g] = flags[g] & enables[g];
  end
  assign hold = |flags;
endmodule

// File: rtl/i2c_xfer_cnt.sv
module i2c_xfer_cnt
  import i2c_xfer_cnt_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             byte_ack,
  input  logic             reload_en,
  input  logic             autoend_en,
  input  logic             stop_set,
  input  logic             reload_ie,
  input  logic             done_ie,
  output logic [CNT_W-1:0] count,
  output logic             reload_flag,
  output logic             done_flag,
  output logic             stop_req,
  output logic             scl_hold,
  output logic             irq_reload,
  output logic             irq_done
);
  logic                    hit, wr_nonzero;
  logic [NUM_IRQ-1:0]      flag_vec, ie_vec, irq_vec;

  xfer_cnt_reg #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .wr(cnt_wr), .wdata(cnt_wdata), .byte_ack(byte_ack),
    .count(count), .hit(hit), .wr_nonzero(wr_nonzero)
  );

  xfer_end_ctrl u_end (
    .clk(clk), .rst(rst), .hit(hit), .wr_nonzero(wr_nonzero),
    .reload_en(reload_en), .autoend_en(autoend_en), .stop_set(stop_set),
    .reload_flag(reload_flag), .done_flag(done_flag), .stop_req(stop_req)
  );

  assign flag_vec[IRQ_RELOAD] = reload_flag;
  assign flag_vec[IRQ_DONE]   = done_flag;
  assign ie_vec[IRQ_RELOAD]   = reload_ie;
  assign ie_vec[IRQ_DONE]     = done_ie;

  xfer_irq_gen #(.NSRC(NUM_IRQ)) u_irq (
    .flags(flag_vec), .enables(ie_vec), .irq(irq_vec), .hold(scl_hold)
  );

  assign irq_reload = irq_vec[IRQ_RELOAD];
  assign irq_done   = irq_vec[IRQ_DONE];

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (count == '0) && !reload_flag && !done_flag && !stop_req);

  p_hold_on_flag_r5: assert property (@(posedge clk) disable iff (rst)
    (reload_flag || done_flag) |-> scl_hold);

  p_irq_done_r9: assert property (@(posedge clk) disable iff (rst)
    irq_done |-> done_flag);

endmodule

// File: tb/i2c_xfer_cnt_tb.sv
module i2c_xfer_cnt_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cnt_wr = 1'b0, byte_ack = 1'b0, stop_set = 1'b0;
  logic [7:0] cnt_wdata = 8'd0;
  logic       reload_en = 1'b0, autoend_en = 1'b0, reload_ie = 1'b0, done_ie = 1'b0;
  logic [7:0] count;
  logic       reload_flag, done_flag, stop_req, scl_hold, irq_reload, irq_done;

  int nchk = 0, nfail = 0;
  logic [7:0] m_cnt = 8'd0;
  logic       m_rl = 1'b0, m_tc = 1'b0, m_stop = 1'b0;

  always #5 clk = ~clk;

  i2c_xfer_cnt u_dut (
    .clk(clk), .rst(rst), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .byte_ack(byte_ack),
    .reload_en(reload_en), .autoend_en(autoend_en), .stop_set(stop_set),
    .reload_ie(reload_ie), .done_ie(done_ie), .count(count),
    .reload_flag(reload_flag), .done_flag(done_flag), .stop_req(stop_req),
    .scl_hold(scl_hold), .irq_reload(irq_reload), .irq_done(irq_done)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // next-state model written from the requirements
  function automatic logic [7:0] nx_cnt();
    if (rst) return 8'd0;
    if (cnt_wr) return cnt_wdata;
    if (byte_ack && m_cnt != 0) return m_cnt - 8'd1;
    return m_cnt;
  endfunction

  task automatic cycle();
    logic       h, hr, ha, hs, sw;
    logic [7:0] c;
    c  = nx_cnt();
    h  = !rst && !cnt_wr && byte_ack && (m_cnt == 8'd1);
    hr = h && reload_en;
    ha = h && !reload_en && autoend_en;
    hs = h && !reload_en && !autoend_en;
    sw = stop_set && m_tc;
    @(posedge clk);
    #1;
    if (rst) begin
      m_rl = 0; m_tc = 0; m_stop = 0;
    end else begin
      if (hr) m_rl = 1; else if (cnt_wr && cnt_wdata != 0) m_rl = 0;
      if (hs) m_tc = 1; else if (sw) m_tc = 0;
      m_stop = ha || sw;
    end
    m_cnt = c;
    chk("R3 count", count, m_cnt);
    chk("R4 reload_flag", reload_flag, m_rl);
    chk("R9 done_flag", done_flag, m_tc);
    chk("R7 stop_req", stop_req, m_stop);
    chk("R5 scl_hold", scl_hold, m_rl | m_tc);
    chk("R4 irq_reload", irq_reload, m_rl & reload_ie);
    chk("R9 irq_done", irq_done, m_tc & done_ie);
  endtask

  task automatic drive(input logic wr, input logic [7:0] wd, input logic bd, input logic ss);
    cnt_wr = wr; cnt_wdata = wd; byte_ack = bd; stop_set = ss;
    cycle();
    cnt_wr = 0; byte_ack = 0; stop_set = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL R1: watchdog expired, actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'h1C2B));
    cycle(); cycle();
    chk("R1 reset count", count, 0);
    chk("R1 reset flags", {reload_flag, done_flag, stop_req, scl_hold}, 0);
    rst = 0;
    drive(0, 0, 0, 0);

    // R3 floor at zero
    drive(0, 0, 1, 0);
    chk("R3 byte at zero", count, 0);
    // R2 write beats byte
    drive(1, 8'd5, 1, 0);
    chk("R2 write priority", count, 5);

    // R6 reload
    reload_en = 1; reload_ie = 1;
    drive(1, 8'd2, 0, 0); drive(0, 0, 1, 0); drive(0, 0, 1, 0);
    chk("R4 reload set", reload_flag, 1);
    drive(1, 8'd0, 0, 0);
    chk("R6 zero write keeps flag", reload_flag, 1);
    drive(1, 8'd3, 0, 0);
    chk("R6 nonzero write clears", reload_flag, 0);

    // R8 both modes
    autoend_en = 1;
    drive(1, 8'd1, 0, 0); drive(0, 0, 1, 0);
    chk("R8 no auto stop", stop_req, 0);
    chk("R8 reload flag", reload_flag, 1);
    drive(1, 8'd1, 0, 0);

    // R7 automatic end
    reload_en = 0;
    drive(0, 0, 1, 0);
    chk("R7 stop pulse", stop_req, 1);
    drive(0, 0, 0, 0);
    chk("R7 stop one cycle", stop_req, 0);

    // R10 software end
    autoend_en = 0; done_ie = 1;
    drive(1, 8'd1, 0, 0); drive(0, 0, 1, 0);
    chk("R9 done set", done_flag, 1);
    drive(0, 0, 0, 1);
    chk("R10 stop issued", stop_req, 1);
    chk("R10 done cleared", done_flag, 0);
    drive(0, 0, 0, 1);
    chk("R10 stop ignored without flag", stop_req, 0);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic       w;
      logic [7:0] v;
      if (($urandom % 40) == 0) begin
        reload_en  = $urandom % 2;
        autoend_en = $urandom % 2;
        reload_ie  = $urandom % 2;
        done_ie    = $urandom % 2;
      end
      w = (($urandom % 6) == 0);
      v = (($urandom % 5) == 0) ? 8'd0 : 8'($urandom % 5 + 1);
      if (($urandom % 300) == 0) begin
        rst = 1; drive(0, 0, 0, 0); rst = 0;
      end else begin
        drive(w, v, ($urandom % 2) == 1, ($urandom % 4) == 0);
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule